// File: doc/BRIEF.md
# External Access Target Responder

This block is the target side of a shared parallel bus. An external master drives a start strobe with a 24-bit address, a direction bit and write data. The block answers from a local word memory, and it ends every transfer it accepts with a one-cycle normal acknowledge or a one-cycle error acknowledge.

A small register port configures the block. A mode register holds a module-off bit, an external-master enable, a 16-bit data path select and an extra wait count. A monitor register holds an 8-bit timeout period and an enable bit. A status register keeps sticky error and timeout flags, which are cleared by writing 1 to them.

The address is decoded in three steps. The most significant bit decides whether the access is seen at all. The next three bits must equal one fixed block code. A low field then selects the memory word. A monitor counts the cycles of each access and cuts it short with an error acknowledge when the programmed period runs out first.

Top module: `ext_target_resp`

## Requirements
- R1: While the module-off bit (mode register bit 0) is 1, a start strobe produces no acknowledge, no error and no memory write.
- R2: While the external-master enable (mode register bit 1) is 0, a start strobe produces no acknowledge, no error and no memory write.
- R3: A start whose address bit 23 is 0 produces no acknowledge, no error and no memory write.
- R4: A start with address bit 23 set whose bits 22:20 differ from the parameter BLOCK_CODE (default 3'b101) gets an error acknowledge in the first cycle after the start edge, and nothing is written.
- R5: A matching access gets its normal acknowledge in cycle 3+W after the start edge, where W is mode register bits 7:4. A write stores the data at word index address[9:2]. Read data is valid in the acknowledge cycle.
- R6: Each normal or error acknowledge lasts exactly one cycle, and the two are never high together.
- R7: Monitor register bits 7:0 give the period P and bit 8 the enable. When the monitor is enabled and P is nonzero with P <= W+1, the access ends with an error acknowledge in cycle P+1 and no write. Otherwise the access ends normally.
- R8: Status register bit 0 is set by every error acknowledge, and bit 1 by every monitor expiry. Both are sticky, both clear when 1 is written to them, and a new set wins over a clear in the same cycle.
- R9: With mode register bit 2 set, a write changes only data bits 15:0 of the word, and a read returns zero in bits 31:16.
- R10: A start strobe that arrives while an access is in progress is ignored.
- R11: After reset the mode register reads 0x1, and the monitor and status registers read 0. Both acknowledges are low. reg_rdata shows the register that reg_addr selected in the previous cycle (0 mode, 1 monitor, 2 status).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read of the selected register |
| bs_start | input | 1 | Transfer start strobe from the external master |
| bs_wr | input | 1 | 1 for write, 0 for read |
| bs_addr | input | 24 | External address |
| bs_wdata | input | 32 | Write data |
| bs_rdata | output | 32 | Read data, valid with bs_ack |
| bs_ack | output | 1 | Normal acknowledge, one cycle |
| bs_err | output | 1 | Error acknowledge, one cycle |

## Verification
Cycles are counted from the edge that samples the start strobe. A mismatched block code answers in cycle 1. A matching access answers in cycle 3+W. A monitor expiry answers in cycle P+1, and the status flags become visible in that same response cycle. Register reads are due one cycle after the select is applied. For each access, the driver pushes the response kind, the exact due cycle and the expected data into a queue. A monitor checks every acknowledge against the head of that queue at the falling edge, so an early, late, missing or unexpected response is reported. Ignored starts are checked by waiting several cycles with the queue empty and then reading the word back.

// File: rtl/etr_pkg.sv
package etr_pkg;
  localparam int REG_W  = 32;
  localparam int MON_W  = 8;
  localparam int LANE_W = 16;

  localparam logic [1:0] REG_MODE = 2'd0;
  localparam logic [1:0] REG_MON  = 2'd1;
  localparam logic [1:0] REG_STS  = 2'd2;

  // mode register bit positions
  localparam int MB_OFF  = 0;
  localparam int MB_XEN  = 1;
  localparam int MB_HALF = 2;
  localparam int MB_WAIT = 4;
  // monitor register enable position
  localparam int MB_MEN  = 8;

  typedef enum logic [0:0] {ST_IDLE, ST_BUSY} seq_st_e;
endpackage

// File: rtl/etr_decode.sv
module etr_decode #(
  parameter int AW = 24,
  parameter int CODE_W = 3,
  parameter logic [CODE_W-1:0] BLOCK_CODE = 3'b101,
  parameter int IDX_W = 8
) (
  input  logic [AW-1:0]    addr,
  output logic             visible,
  output logic             hit,
  output logic [IDX_W-1:0] idx
);
  assign visible = addr[AW-1];
  assign hit     = (addr[AW-2 -: CODE_W] == BLOCK_CODE);
  assign idx     = addr[IDX_W+1:2];
endmodule

// File: rtl/etr_regs.sv
module etr_regs
  import etr_pkg::*;
#(
  parameter int WAIT_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [1:0]        reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic              set_err,
  input  logic              set_tmo,
  output logic              mode_off,
  output logic              mode_xen,
  output logic              mode_half,
  output logic [WAIT_W-1:0] mode_wait,
  output logic              mon_en,
  output logic [MON_W-1:0]  mon_period,
  output logic              sts_err,
  output logic              sts_tmo
);
  logic             wr_mode, wr_mon, wr_sts;
  logic [REG_W-1:0] rd_nx;

  assign wr_mode = reg_we && (reg_addr == REG_MODE);
  assign wr_mon  = reg_we && (reg_addr == REG_MON);
  assign wr_sts  = reg_we && (reg_addr == REG_STS);

  always_comb begin
    rd_nx = '0;
    case (reg_addr)
      REG_MODE: begin
        rd_nx[MB_OFF]                 = mode_off;
        rd_nx[MB_XEN]                 = mode_xen;
        rd_nx[MB_HALF]                = mode_half;
        rd_nx[MB_WAIT +: WAIT_W]      = mode_wait;
      end
      REG_MON: begin
        rd_nx[MON_W-1:0]              = mon_period;
        rd_nx[MB_MEN]                 = mon_en;
      end
      REG_STS: begin
        rd_nx[0]                      = sts_err;
        rd_nx[1]                      = sts_tmo;
      end
      default: rd_nx = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_off   <= 1'b1;
      mode_xen   <= 1'b0;
      mode_half  <= 1'b0;
      mode_wait  <= '0;
      mon_en     <= 1'b0;
      mon_period <= '0;
      sts_err    <= 1'b0;
      sts_tmo    <= 1'b0;
      reg_rdata  <= '0;
    end else begin
      if (wr_mode) begin
        mode_off  <= reg_wdata[MB_OFF];
        mode_xen  <= reg_wdata[MB_XEN];
        mode_half <= reg_wdata[MB_HALF];
        mode_wait <= reg_wdata[MB_WAIT +: WAIT_W];
      end
      if (wr_mon) begin
        mon_period <= reg_wdata[MON_W-1:0];
        mon_en     <= reg_wdata[MB_MEN];
      end
      sts_err   <= set_err || (sts_err && !(wr_sts && reg_wdata[0]));
      sts_tmo   <= set_tmo || (sts_tmo && !(wr_sts && reg_wdata[1]));
      reg_rdata <= rd_nx;
    end
  end
endmodule

// File: rtl/etr_seq.sv
module etr_seq
  import etr_pkg::*;
#(
  parameter int WAIT_W = 4,
  parameter int IDX_W  = 8,
  parameter int DW     = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              wr,
  input  logic              visible,
  input  logic              hit,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DW-1:0]     wdata,
  input  logic              mode_off,
  input  logic              mode_xen,
  input  logic              mode_half,
  input  logic [WAIT_W-1:0] mode_wait,
  input  logic              mon_en,
  input  logic [MON_W-1:0]  mon_period,
  output logic              busy,
  output logic              ack,
  output logic              err,
  output logic              set_err,
  output logic              set_tmo,
  output logic              mem_we,
  output logic              mem_re,
  output logic              half_q,
  output logic [IDX_W-1:0]  idx_q,
  output logic [DW-1:0]     wdata_q
);
  localparam int AGE_W = MON_W + 1;
  localparam logic [AGE_W-1:0] AGE_ONE = AGE_W'(1);
  localparam logic [AGE_W-1:0] AGE_TWO = AGE_W'(2);

  seq_st_e           st;
  logic [AGE_W-1:0]  age;
  logic [WAIT_W-1:0] wait_q;
  logic              wr_q;
  logic              accept, done, expire;

  assign busy    = (st == ST_BUSY);
  assign accept  = !busy && start && !mode_off && mode_xen && visible;
  assign done    = busy && (age == AGE_W'(wait_q) + AGE_TWO);
  assign expire  = busy && !done && mon_en && (mon_period != '0) &&
                   (age == AGE_W'(mon_period));
  assign set_tmo = expire;
  assign set_err = expire || (accept && !hit);
  assign mem_we  = done && wr_q;
  assign mem_re  = done && !wr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_IDLE;
      age     <= '0;
      wait_q  <= '0;
      wr_q    <= 1'b0;
      half_q  <= 1'b0;
      idx_q   <= '0;
      wdata_q <= '0;
      ack     <= 1'b0;
      err     <= 1'b0;
    end else begin
      ack <= 1'b0;
      err <= 1'b0;
      if (accept) begin
        if (hit) begin
          st      <= ST_BUSY;
          age     <= AGE_ONE;
          wait_q  <= mode_wait;
          wr_q    <= wr;
          half_q  <= mode_half;
          idx_q   <= idx;
          wdata_q <= wdata;
        end else begin
          err <= 1'b1;
        end
      end else if (busy) begin
        if (done) begin
          ack <= 1'b1;
          st  <= ST_IDLE;
        end else if (expire) begin
          err <= 1'b1;
          st  <= ST_IDLE;
        end else begin
          age <= age + AGE_ONE;
        end
      end
    end
  end
endmodule

// File: rtl/etr_lane_mem.sv
module etr_lane_mem #(
  parameter int DEPTH = 256,
  parameter int IDX_W = 8,
  parameter int LW    = 16
) (
  input  logic             clk,
  input  logic             we,
  input  logic             re,
  input  logic [IDX_W-1:0] idx,
  input  logic [LW-1:0]    wdata,
  output logic [LW-1:0]    rdata
);
  logic [LW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[idx] <= wdata;
    if (re) rdata <= mem[idx];
  end
endmodule

// File: rtl/ext_target_resp.sv
module ext_target_resp
  import etr_pkg::*;
#(
  parameter int AW = 24,
  parameter int DW = 32,
  parameter int CODE_W = 3,
  parameter logic [CODE_W-1:0] BLOCK_CODE = 3'b101,
  parameter int IDX_W = 8,
  parameter int WAIT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reg_we,
  input  logic [1:0]       reg_addr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  input  logic             bs_start,
  input  logic             bs_wr,
  input  logic [AW-1:0]    bs_addr,
  input  logic [DW-1:0]    bs_wdata,
  output logic [DW-1:0]    bs_rdata,
  output logic             bs_ack,
  output logic             bs_err
);
  localparam int DEPTH = 1 << IDX_W;
  localparam int LANES = DW / LANE_W;

  logic              visible, hit;
  logic [IDX_W-1:0]  idx, idx_q;
  logic [DW-1:0]     wdata_q;
  logic              mode_off, mode_xen, mode_half, mon_en;
  logic [WAIT_W-1:0] mode_wait;
  logic [MON_W-1:0]  mon_period;
  logic              sts_err, sts_tmo, set_err, set_tmo;
  logic              busy, mem_we, mem_re, half_q, rd_half;

  etr_decode #(.AW(AW), .CODE_W(CODE_W), .BLOCK_CODE(BLOCK_CODE), .IDX_W(IDX_W)) u_dec (
    .addr(bs_addr), .visible(visible), .hit(hit), .idx(idx)
  );

  etr_regs #(.WAIT_W(WAIT_W)) u_regs (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .set_err(set_err), .set_tmo(set_tmo),
    .mode_off(mode_off), .mode_xen(mode_xen), .mode_half(mode_half),
    .mode_wait(mode_wait), .mon_en(mon_en), .mon_period(mon_period),
    .sts_err(sts_err), .sts_tmo(sts_tmo)
  );

  etr_seq #(.WAIT_W(WAIT_W), .IDX_W(IDX_W), .DW(DW)) u_seq (
    .clk(clk), .rst(rst), .start(bs_start), .wr(bs_wr),
    .visible(visible), .hit(hit), .idx(idx), .wdata(bs_wdata),
    .mode_off(mode_off), .mode_xen(mode_xen), .mode_half(mode_half),
    .mode_wait(mode_wait), .mon_en(mon_en), .mon_period(mon_period),
    .busy(busy), .ack(bs_ack), .err(bs_err),
    .set_err(set_err), .set_tmo(set_tmo),
    .mem_we(mem_we), .mem_re(mem_re), .half_q(half_q),
    .idx_q(idx_q), .wdata_q(wdata_q)
  );

  always_ff @(posedge clk) begin
    if (rst)         rd_half <= 1'b0;
    else if (mem_re) rd_half <= half_q;
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LANE_W-1:0] lane_rd;
    logic              lane_we;
    if (l == 0) begin : g_low
      assign lane_we = mem_we;
      assign bs_rdata[l*LANE_W +: LANE_W] = lane_rd;
    end else begin : g_high
      assign lane_we = mem_we && !half_q;
      assign bs_rdata[l*LANE_W +: LANE_W] = rd_half ? '0 : lane_rd;
    end
    etr_lane_mem #(.DEPTH(DEPTH), .IDX_W(IDX_W), .LW(LANE_W)) u_mem (
      .clk(clk), .we(lane_we), .re(mem_re), .idx(idx_q),
      .wdata(wdata_q[l*LANE_W +: LANE_W]), .rdata(lane_rd)
    );
  end
endmodule

// File: rtl/etr_chk.sv
module etr_chk #(
  parameter int AW = 24,
  parameter int CODE_W = 3,
  parameter logic [CODE_W-1:0] BLOCK_CODE = 3'b101
) (
  input logic          clk,
  input logic          rst,
  input logic          bs_start,
  input logic [AW-1:0] bs_addr,
  input logic          bs_ack,
  input logic          bs_err,
  input logic          busy,
  input logic          mode_off,
  input logic          mode_xen,
  input logic          sts_err
);
  logic [1:0] since;
  logic       taken;

  assign taken = !busy && bs_start && !mode_off && mode_xen && bs_addr[AW-1];

  always_ff @(posedge clk) begin
    if (rst)                since <= 2'd0;
    else if (taken)         since <= 2'd1;
    else if (since != 2'd3) since <= since + 2'd1;
  end

  a_r6_ack_single: assert property (@(posedge clk) disable iff (rst)
    bs_ack |=> !bs_ack);
  a_r6_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(bs_ack && bs_err));
  // R1 R2 R3: gated starts get no response
  a_r1_gated_quiet: assert property (@(posedge clk) disable iff (rst)
    (!busy && bs_start && (mode_off || !mode_xen || !bs_addr[AW-1])) |=> (!bs_ack && !bs_err));
  a_r4_miss_err: assert property (@(posedge clk) disable iff (rst)
    (taken && (bs_addr[AW-2 -: CODE_W] != BLOCK_CODE)) |=> bs_err);
  a_r5_min_latency: assert property (@(posedge clk) disable iff (rst)
    bs_ack |-> (since == 2'd3));
  a_r8_err_flag: assert property (@(posedge clk) disable iff (rst)
    bs_err |-> sts_err);
endmodule

bind ext_target_resp etr_chk #(.AW(AW), .CODE_W(CODE_W), .BLOCK_CODE(BLOCK_CODE)) u_chk (
  .clk(clk), .rst(rst), .bs_start(bs_start), .bs_addr(bs_addr),
  .bs_ack(bs_ack), .bs_err(bs_err), .busy(busy),
  .mode_off(mode_off), .mode_xen(mode_xen), .sts_err(sts_err)
);

// File: tb/ext_target_resp_tb.sv
module ext_target_resp_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        bs_start = 1'b0;
  logic        bs_wr = 1'b0;
  logic [23:0] bs_addr = '0;
  logic [31:0] bs_wdata = '0;
  logic [31:0] bs_rdata;
  logic        bs_ack, bs_err;

  int n_checks = 0;
  int n_errors = 0;
  int cyc = 0;

  typedef struct {
    bit    is_err;
    bit    has_data;
    logic [31:0] data;
    int    due;
    string req;
  } exp_t;
  exp_t sb[$];

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  ext_target_resp u_dut (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .bs_start(bs_start), .bs_wr(bs_wr), .bs_addr(bs_addr),
    .bs_wdata(bs_wdata), .bs_rdata(bs_rdata), .bs_ack(bs_ack), .bs_err(bs_err)
  );

  function automatic logic [23:0] mk(bit vis, logic [2:0] code, logic [7:0] idx);
    return {vis, code, 10'h0, idx, 2'b00};
  endfunction

  task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // scoreboard monitor
  bit prev_resp = 1'b0;
  always @(negedge clk) begin
    if (!rst) begin
      if (prev_resp) check(!bs_ack && !bs_err, "R6", "response longer than one cycle",
                           {30'h0, bs_ack, bs_err}, 32'h0);
      if (bs_ack && bs_err) check(1'b0, "R6", "ack and err together", 32'h3, 32'h0);
      if (bs_ack || bs_err) begin
        if (sb.size() == 0) begin
          check(1'b0, "R10", "unexpected response", {30'h0, bs_ack, bs_err}, 32'h0);
        end else begin
          exp_t e;
          e = sb.pop_front();
          check(bs_err == e.is_err, e.req, "response kind", {31'h0, bs_err}, {31'h0, e.is_err});
          check(cyc == e.due, e.req, "response cycle", cyc, e.due);
          if (e.has_data) check(bs_rdata == e.data, e.req, "read data", bs_rdata, e.data);
        end
      end
      prev_resp = bs_ack || bs_err;
    end
  end

  task automatic reg_write(logic [1:0] a, logic [31:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic reg_check(logic [1:0] a, logic [31:0] exp, string req);
    @(negedge clk); reg_addr = a;
    @(negedge clk); check(reg_rdata == exp, req, "register read", reg_rdata, exp);
  endtask

  // kind: 0 no response, 1 ack, 2 err; lat is the response cycle number
  task automatic xfer(logic [23:0] a, bit wr, logic [31:0] d, int kind,
                      logic [31:0] exp, int lat, string req);
    exp_t e;
    int   s;
    @(negedge clk);
    bs_start = 1'b1; bs_addr = a; bs_wr = wr; bs_wdata = d;
    s = cyc + 1;
    if (kind != 0) begin
      e.is_err = (kind == 2); e.has_data = (kind == 1) && !wr;
      e.data = exp; e.due = s + lat - 1; e.req = req;
      sb.push_back(e);
    end
    @(negedge clk); bs_start = 1'b0;
    repeat (lat + 3) @(negedge clk);
    check(sb.size() == 0, req, "missing response", sb.size(), 0);
    sb.delete();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    check(1'b0, "R11", "watchdog expired", cyc, 0);
    $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(!bs_ack && !bs_err, "R11", "acks after reset", {30'h0, bs_ack, bs_err}, 0);
    reg_check(2'd0, 32'h1, "R11");
    reg_check(2'd1, 32'h0, "R11");
    reg_check(2'd2, 32'h0, "R11");

    // R5 basic write and read, W=0
    reg_write(2'd0, 32'h2);
    xfer(mk(1, 3'b101, 8'd5), 1, 32'h12345678, 1, 0, 3, "R5");
    xfer(mk(1, 3'b101, 8'd5), 0, 0, 1, 32'h12345678, 3, "R5");

    // R1 module off
    reg_write(2'd0, 32'h3);
    xfer(mk(1, 3'b101, 8'd5), 1, 32'hDEAD0001, 0, 0, 8, "R1");
    // R2 external master disabled
    reg_write(2'd0, 32'h0);
    xfer(mk(1, 3'b101, 8'd5), 1, 32'hDEAD0002, 0, 0, 8, "R2");
    // R3 invisible address
    reg_write(2'd0, 32'h2);
    xfer(mk(0, 3'b101, 8'd5), 1, 32'hDEAD0003, 0, 0, 8, "R3");
    xfer(mk(1, 3'b101, 8'd5), 0, 0, 1, 32'h12345678, 3, "R3");

    // R4 code mismatch
    xfer(mk(1, 3'b010, 8'd5), 1, 32'hDEAD0004, 2, 0, 1, "R4");
    xfer(mk(1, 3'b101, 8'd5), 0, 0, 1, 32'h12345678, 3, "R4");
    reg_check(2'd2, 32'h1, "R8");
    reg_write(2'd2, 32'h1);
    reg_check(2'd2, 32'h0, "R8");

    // R5 with W=3
    reg_write(2'd0, 32'h32);
    xfer(mk(1, 3'b101, 8'd9), 1, 32'hCAFEF00D, 1, 0, 6, "R5");
    xfer(mk(1, 3'b101, 8'd9), 0, 0, 1, 32'hCAFEF00D, 6, "R5");

    // R7 monitor expiry P=2, W=3 -> error in cycle 3
    reg_write(2'd1, 32'h102);
    reg_check(2'd1, 32'h102, "R11");
    xfer(mk(1, 3'b101, 8'd9), 1, 32'h0, 2, 0, 3, "R7");
    reg_check(2'd2, 32'h3, "R8");
    reg_write(2'd2, 32'h3);
    reg_check(2'd2, 32'h0, "R8");
    // R7 P = W+2: normal completion, and the cut write left no trace
    reg_write(2'd1, 32'h105);
    xfer(mk(1, 3'b101, 8'd9), 0, 0, 1, 32'hCAFEF00D, 6, "R7");
    reg_write(2'd1, 32'h0);

    // R9 half data path
    reg_write(2'd0, 32'h6);
    xfer(mk(1, 3'b101, 8'd9), 1, 32'hAAAABBBB, 1, 0, 3, "R9");
    xfer(mk(1, 3'b101, 8'd9), 0, 0, 1, 32'h0000BBBB, 3, "R9");
    reg_write(2'd0, 32'h2);
    xfer(mk(1, 3'b101, 8'd9), 0, 0, 1, 32'hCAFEBBBB, 3, "R9");

    // R10 start during a busy access
    reg_write(2'd0, 32'h32);
    begin
      exp_t e;
      int s;
      @(negedge clk);
      bs_start = 1'b1; bs_wr = 1'b1; bs_addr = mk(1, 3'b101, 8'd7); bs_wdata = 32'h11111111;
      s = cyc + 1;
      e.is_err = 1'b0; e.has_data = 1'b0; e.data = 0; e.due = s + 5; e.req = "R10";
      sb.push_back(e);
      @(negedge clk); bs_wdata = 32'h22222222;
      @(negedge clk); bs_addr = mk(1, 3'b010, 8'd7);
      @(negedge clk); bs_start = 1'b0;
      repeat (10) @(negedge clk);
      check(sb.size() == 0, "R10", "missing response", sb.size(), 0);
    end
    xfer(mk(1, 3'b101, 8'd7), 0, 0, 1, 32'h11111111, 6, "R10");

    repeat (4) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
    $finish;
  end
endmodule